// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block gathers hardware interrupt sources into one host-visible flag register, gates it with an enable mask and drives a single host interrupt line. A second flag register holds DMA-level detail (error, high-priority receive, two receive channels, two transmit channels). Each DMA event also raises a summary flag in the main register, so the host can take one interrupt and then inspect the DMA detail. Flags are sticky. Hardware sets them, and the host clears one only by writing a one to it.

To cut the host's interrupt rate, a coalescing timer can hold the line low for a programmable number of 32-tick units after a masked-in flag first appears. A high-priority DMA receive flag skips this wait. A second byte of the coalescing register sets up a periodic receive flag that fires at a programmable interval. Host accesses use a simple register port with a 2-bit word address and per-byte write enables. Reads are combinational from the address.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the main flags, the enable mask and the DMA flags all read 0, the coalescing register (address 3) reads 0x0000_0040, and `host_irq_o` is low.
- R2: Main flags (address 0) are set by `src_evt_i` pulses only at bits 26, 25, 7, 6, 3, 1 and 0; pulses on any other bit of `src_evt_i` are ignored. A main flag stays set until the host writes a 1 to it in an enabled byte lane, and written zeros leave flags unchanged.
- R3: DMA flags (address 2) are set by `dma_evt_i` pulses only at bits 31 (error), 30 (high-priority receive), 17, 16 (receive channels), 1 and 0 (transmit channels); pulses on other bits are ignored. Clearing works the same write-one way as for the main flags.
- R4: A DMA event at bit 16, 17 or 30 also sets main bit 31. A DMA event at bit 0 or 1 sets main bit 27, and one at bit 31 sets main bit 29. Clearing a main summary flag leaves the DMA flags unchanged.
- R5: If a write-one clear and a setting event reach the same flag in the same cycle, the flag stays set.
- R6: Only flags whose mask bit (address 1, same bit position) is 1 can raise `host_irq_o`. With a zero timeout, the line rises one cycle after a masked-in flag is registered, or after the mask is enabled for a set flag. It falls one cycle after the last masked-in flag is cleared.
- R7: With timeout byte T (address 3, bits 7:0) nonzero, the line stays low after a masked-in flag appears. It rises on the clock edge that counts the (T × TICKS_PER_UNIT)-th `tick_us_i` pulse, counting starts in the cycle after the flag is first seen, and the line then stays high while any masked-in flag remains.
- R8: While DMA flag 30 and main flag 31 are both set and mask bit 31 is 1, the hold-off is skipped and the line rises one cycle later.
- R9: If all masked-in flags are cleared during the hold-off, the line never rises for them. A later flag starts a full new hold-off.
- R10: A nonzero periodic byte P (address 3, bits 15:8) sets main bit 28 once every P × TICKS_PER_UNIT tick pulses, and P = 0 stops it. A write to byte lane 1 alone leaves the timeout byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 main flags, 1 mask, 2 DMA flags, 3 coalescing |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte-lane write enables |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| src_evt_i | input | 32 | Per-source event pulses for the main flags |
| dma_evt_i | input | 32 | Per-source event pulses for the DMA flags |
| tick_us_i | input | 1 | One-microsecond tick pulse |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The embedded assertions check four rules on every cycle. No flag drops without a write-one clear, and a setting event always wins. The line never leaves idle straight to asserted unless the timeout is zero or the bypass holds. A high line always follows a cycle with masked-in flags pending. Only the directed scenarios can show the exact hold-off length in ticks and the bit mapping from DMA events to summary flags. The same applies to ignored event bits, byte-lane write effects and the period of the periodic flag.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned LANES  = REG_W / 8;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_MAIN = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_DMA  = 2'd2;
    localparam logic [ADDR_W-1:0] A_COAL = 2'd3;

    // main flag positions that are derived internally
    localparam int unsigned B_DMA_RX  = 31;
    localparam int unsigned B_HW_ERR  = 29;
    localparam int unsigned B_PERIOD  = 28;
    localparam int unsigned B_DMA_TX  = 27;

    // DMA flag positions
    localparam int unsigned D_ERR   = 31;
    localparam int unsigned D_HIPRI = 30;

    localparam logic [REG_W-1:0] MAIN_DIRECT = 32'h0600_00CB;
    localparam logic [REG_W-1:0] MAIN_IMPL   = MAIN_DIRECT | 32'hB800_0000;
    localparam logic [REG_W-1:0] DMA_IMPL    = 32'hC003_0003;
    localparam logic [REG_W-1:0] DMA_RX_GRP  = 32'h4003_0000;
    localparam logic [REG_W-1:0] DMA_TX_GRP  = 32'h0000_0003;

    localparam logic [7:0] TMO_RESET = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIRE = 2'd2
    } hold_state_e;

endpackage

// File: rtl/intc_unit_timer.sv
module intc_unit_timer #(
    parameter int unsigned TICKS_PER_UNIT = 32,
    parameter int unsigned LIMIT_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               expire_o
);
    localparam int unsigned SUB_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_UNIT - 1);

    typedef struct packed {
        logic [SUB_W-1:0]   sub;
        logic [LIMIT_W-1:0] unit;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = 1'b0;
        if (clear_i) begin
            tmr_d = '0;
        end else if (tick_i && (limit_i != '0)) begin
            if (tmr_q.sub == SUB_LAST) begin
                tmr_d.sub = '0;
                if (tmr_q.unit >= limit_i - LIMIT_W'(1)) begin
                    tmr_d.unit = '0;
                    expire_o   = 1'b1;
                end else begin
                    tmr_d.unit = tmr_q.unit + LIMIT_W'(1);
                end
            end else begin
                tmr_d.sub = tmr_q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // prescaler never leaves its range (hold-off length, R7)
    assert_prescale_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tmr_q.sub) < TICKS_PER_UNIT));

endmodule

// File: rtl/intc_flag_reg.sv
module intc_flag_reg #(
    parameter int unsigned  W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } flag_t;

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d       = flg_q;
        flg_d.flags = ((flg_q.flags & ~clr_i) | set_i) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags_o = flg_q.flags;

    // a flag only drops after a write-one clear
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(flags_o) & ~$past(clr_i)) & ~flags_o) == '0));

    // a setting event beats a same-cycle clear
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(set_i) & IMPL) & ~flags_o) == '0));

endmodule

// File: rtl/intc_hold_fsm.sv
module intc_hold_fsm
    import intc_pkg::*;
#(
    parameter int unsigned TICKS_PER_UNIT = 32,
    parameter int unsigned TMO_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending_i,
    input  logic             bypass_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             irq_o
);
    typedef struct packed {
        hold_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic expire;

    intc_unit_timer #(
        .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .LIMIT_W       (TMO_W)
    ) u_hold_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (fsm_q.st != ST_HOLD),
        .tick_i  (tick_i),
        .limit_i (tmo_i),
        .expire_o(expire)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (pending_i) begin
                    if ((tmo_i == '0) || bypass_i) fsm_d.st = ST_FIRE;
                    else                           fsm_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!pending_i)                fsm_d.st = ST_IDLE;
                else if (bypass_i || expire)   fsm_d.st = ST_FIRE;
            end
            ST_FIRE: begin
                if (!pending_i) fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q.st <= ST_IDLE;
        else        fsm_q    <= fsm_d;
    end

    assign irq_o = (fsm_q.st == ST_FIRE);

    // leaving idle straight to asserted needs zero timeout or bypass
    assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.st) == ST_IDLE && fsm_q.st == ST_FIRE)
        |-> ($past(tmo_i) == '0 || $past(bypass_i)));

    // a high line follows a cycle with masked-in flags pending
    assert_irq_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pending_i));

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned TICKS_PER_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [LANES-1:0]  reg_be_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [REG_W-1:0]  src_evt_i,
    input  logic [REG_W-1:0]  dma_evt_i,
    input  logic              tick_us_i,
    output logic              host_irq_o
);
    localparam int unsigned TMO_W = 8;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [TMO_W-1:0] per;
        logic [TMO_W-1:0] tmo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] wbits;
    logic [REG_W-1:0] main_set, main_clr, main_flags;
    logic [REG_W-1:0] dma_set, dma_clr, dma_flags;
    logic             per_expire;
    logic             pending, bypass;
    logic             rx_hit, tx_hit, err_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{reg_be_i[g]}};
    end

    assign wbits = reg_wdata_i & lane_mask;

    // DMA events feeding the main summary flags
    assign rx_hit  = |(dma_evt_i & DMA_RX_GRP);
    assign tx_hit  = |(dma_evt_i & DMA_TX_GRP);
    assign err_hit = dma_evt_i[D_ERR];

    always_comb begin
        main_set           = src_evt_i & MAIN_DIRECT;
        main_set[B_DMA_RX] = rx_hit;
        main_set[B_DMA_TX] = tx_hit;
        main_set[B_HW_ERR] = err_hit;
        main_set[B_PERIOD] = per_expire;
    end

    assign main_clr = (reg_wr_i && reg_addr_i == A_MAIN) ? wbits : '0;
    assign dma_set  = dma_evt_i;
    assign dma_clr  = (reg_wr_i && reg_addr_i == A_DMA) ? wbits : '0;

    intc_flag_reg #(.W(REG_W), .IMPL(MAIN_IMPL)) u_main_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (main_set),
        .clr_i  (main_clr),
        .flags_o(main_flags)
    );

    intc_flag_reg #(.W(REG_W), .IMPL(DMA_IMPL)) u_dma_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (dma_set),
        .clr_i  (dma_clr),
        .flags_o(dma_flags)
    );

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_i && reg_addr_i == A_MASK)
            cfg_d.mask = (cfg_q.mask & ~lane_mask) | wbits;
        if (reg_wr_i && reg_addr_i == A_COAL) begin
            if (reg_be_i[0]) cfg_d.tmo = reg_wdata_i[7:0];
            if (reg_be_i[1]) cfg_d.per = reg_wdata_i[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mask <= '0;
            cfg_q.per  <= '0;
            cfg_q.tmo  <= TMO_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    intc_unit_timer #(
        .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .LIMIT_W       (TMO_W)
    ) u_period_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cfg_q.per == '0),
        .tick_i  (tick_us_i),
        .limit_i (cfg_q.per),
        .expire_o(per_expire)
    );

    assign pending = |(main_flags & cfg_q.mask);
    assign bypass  = dma_flags[D_HIPRI] & main_flags[B_DMA_RX] & cfg_q.mask[B_DMA_RX];

    intc_hold_fsm #(
        .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .TMO_W         (TMO_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending_i(pending),
        .bypass_i (bypass),
        .tick_i   (tick_us_i),
        .tmo_i    (cfg_q.tmo),
        .irq_o    (host_irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            A_MAIN:  reg_rdata_o = main_flags;
            A_MASK:  reg_rdata_o = cfg_q.mask;
            A_DMA:   reg_rdata_o = dma_flags;
            default: reg_rdata_o = {16'h0, cfg_q.per, cfg_q.tmo};
        endcase
    end

endmodule

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;

    localparam int unsigned TPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_rdata;
    logic [31:0] src_evt = '0;
    logic [31:0] dma_evt = '0;
    logic        tick_us = 1'b1;
    logic        host_irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_coalesce_ctrl #(.TICKS_PER_UNIT(TPU)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_be_i   (reg_be),
        .reg_rdata_o(reg_rdata),
        .src_evt_i  (src_evt),
        .dma_evt_i  (dma_evt),
        .tick_us_i  (tick_us),
        .host_irq_o (host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] s, input logic [31:0] dm);
        src_evt = s; dma_evt = dm;
        @(negedge clk);
        src_evt = '0; dma_evt = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cleanup();
        wr(2'd1, 32'h0, 4'hF);
        wr(2'd0, 32'hFFFF_FFFF, 4'hF);
        wr(2'd2, 32'hFFFF_FFFF, 4'hF);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 main", v, 32'h0);
        rd(2'd1, v); check("R1 mask", v, 32'h0);
        rd(2'd2, v); check("R1 dma", v, 32'h0);
        rd(2'd3, v); check("R1 coal", v, 32'h0000_0040);
        check("R1 irq", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_main_flags();
        logic [31:0] v;
        pulse(32'hFFFF_FFFF, 32'h0);
        rd(2'd0, v); check("R2 direct bits only", v, 32'h0600_00CB);
        wr(2'd0, 32'h0200_0001, 4'hF);
        rd(2'd0, v); check("R2 write-one clear", v, 32'h0400_00CA);
        wr(2'd0, 32'hFFFF_FFFF, 4'h1);
        rd(2'd0, v); check("R2 byte lane clear", v, 32'h0400_0000);
        idle(3);
        rd(2'd0, v); check("R2 sticky", v, 32'h0400_0000);
        cleanup();
    endtask

    task automatic t_dma_flags();
        logic [31:0] v;
        pulse(32'h0, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R3 dma bits only", v, 32'hC003_0003);
        rd(2'd0, v); check("R4 all summaries", v, 32'hA800_0000);
        cleanup();
        pulse(32'h0, 32'h0001_0000);
        rd(2'd0, v); check("R4 rx0 summary", v, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000, 4'hF);
        rd(2'd0, v); check("R4 summary cleared", v, 32'h0);
        rd(2'd2, v); check("R4 dma kept", v, 32'h0001_0000);
        pulse(32'h0, 32'h0000_0002);
        rd(2'd0, v); check("R4 tx1 summary", v, 32'h0800_0000);
        pulse(32'h0, 32'h8000_0020);
        rd(2'd0, v); check("R4 err summary", v, 32'h2800_0000);
        rd(2'd2, v); check("R3 unused dma bit", v, 32'h8001_0002);
        cleanup();
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pulse(32'h0000_0003, 32'h0);
        src_evt = 32'h0000_0001;
        wr(2'd0, 32'h0000_0003, 4'hF);
        src_evt = '0;
        rd(2'd0, v); check("R5 event wins", v, 32'h0000_0001);
        cleanup();
    endtask

    task automatic t_mask();
        wr(2'd3, 32'h0000_0000, 4'h1);
        pulse(32'h0000_0008, 32'h0);
        idle(3);
        check("R6 unmasked quiet", {31'h0, host_irq}, 32'h0);
        wr(2'd1, 32'h0000_0008, 4'h1);
        check("R6 same cycle", {31'h0, host_irq}, 32'h0);
        @(negedge clk);
        check("R6 rises", {31'h0, host_irq}, 32'h1);
        wr(2'd0, 32'h0000_0008, 4'h1);
        @(negedge clk);
        check("R6 falls", {31'h0, host_irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_holdoff();
        wr(2'd3, 32'h0000_0003, 4'h1);
        wr(2'd1, 32'h0000_0001, 4'hF);
        pulse(32'h0000_0001, 32'h0);
        idle(3 * TPU);
        check("R7 held low", {31'h0, host_irq}, 32'h0);
        @(negedge clk);
        check("R7 rises at expiry", {31'h0, host_irq}, 32'h1);
        idle(5);
        check("R7 stays high", {31'h0, host_irq}, 32'h1);
        cleanup();
    endtask

    task automatic t_bypass();
        wr(2'd3, 32'h0000_0040, 4'h1);
        wr(2'd1, 32'h8000_0000, 4'hF);
        pulse(32'h0, 32'h4000_0000);
        @(negedge clk);
        check("R8 bypass", {31'h0, host_irq}, 32'h1);
        cleanup();
        pulse(32'h0, 32'h0001_0000);
        idle(4);
        check("R8 no bypass ch0", {31'h0, host_irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_abandon();
        wr(2'd3, 32'h0000_0003, 4'h1);
        wr(2'd1, 32'h0000_0002, 4'hF);
        pulse(32'h0000_0002, 32'h0);
        idle(4);
        wr(2'd0, 32'h0000_0002, 4'hF);
        idle(15);
        check("R9 abandoned", {31'h0, host_irq}, 32'h0);
        pulse(32'h0000_0002, 32'h0);
        idle(3 * TPU);
        check("R9 fresh hold low", {31'h0, host_irq}, 32'h0);
        @(negedge clk);
        check("R9 fresh hold rises", {31'h0, host_irq}, 32'h1);
        cleanup();
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(2'd3, 32'h0000_0011, 4'h1);
        wr(2'd3, 32'hFFFF_0200, 4'h2);
        rd(2'd3, v); check("R10 lane1 only", v, 32'h0000_0211);
        idle(2 * TPU - 2);
        rd(2'd0, v); check("R10 before period", v, 32'h0);
        idle(2);
        rd(2'd0, v); check("R10 period flag", v, 32'h1000_0000);
        wr(2'd3, 32'h0000_0000, 4'h2);
        wr(2'd0, 32'h1000_0000, 4'hF);
        idle(20);
        rd(2'd0, v); check("R10 disabled", v, 32'h0);
        cleanup();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_main_flags();
        t_dma_flags();
        t_collision();
        t_mask();
        t_holdoff();
        t_bypass();
        t_abandon();
        t_periodic();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule